// File: doc/BRIEF.md
# Sponge Authenticated-Encryption Sequencer (64-bit rate)

This block performs authenticated encryption with a 128-bit key, a 128-bit nonce and a 128-bit tag. It is built around a 320-bit sponge state held as five 64-bit words, with a permutation that computes one round per clock cycle. A one-cycle `start` pulse latches the key and nonce. The block then walks through four phases: initialization, absorption of associated data, encryption of plaintext, and finalization. At the end it presents the tag.

Associated data and plaintext enter on a single 64-bit valid/ready stream. Associated data comes first and plaintext follows. Each phase ends with a block flagged `in_last`, which holds 0 to 7 valid bytes, so a message whose length is a multiple of eight ends with an empty last block. Ciphertext leaves one block per plaintext block. The tag appears with a one-cycle valid pulse. A caller with no associated data raises `no_ad` together with `start`, and the stream then carries plaintext only.

Top module: `ascon128_enc`

## Requirements
- R1: While reset is held and right after it, `busy`, `in_ready`, `ct_valid` and `tag_valid` are low.
- R2: A `start` seen while idle loads the state as word0 = IV (0x80400c0600000000), word1/word2 = key upper/lower 64 bits, word3/word4 = nonce upper/lower 64 bits. The block then runs 12 rounds and XORs the key into word3/word4. `in_ready` first reads high on the 13th cycle after the start edge.
- R3: `start` has no effect while `busy` is high: the latched key, the nonce and the sequence already running are kept. While idle, `in_ready` is low.
- R4: Stream byte order is `in_data[63:56]` = first byte. A non-last block is taken as 8 full bytes and `in_bytes` is ignored. A last block keeps its first `in_bytes` (0..7) bytes, ignores the rest, and is padded with 0x80 in the byte that follows them, then zeros. Each padded block is XORed into word0.
- R5: After every block that is not a final plaintext block, the block runs 6 rounds, and `in_ready` is low for exactly those 6 cycles.
- R6: After the last associated-data block, bit 0 of word4 is inverted. When `no_ad` was set at start, no associated-data block is accepted, but the inversion is still applied after initialization.
- R7: For each plaintext block, `ct_valid` is high for exactly the cycle after the handshake. `ct_data` is the new word0, with bytes at positions beyond the block's byte count forced to zero. `ct_bytes` is 8 for a non-last block and `in_bytes` for the last one, and `ct_last` copies `in_last`. Associated-data blocks produce no ciphertext.
- R8: After the last plaintext block, the key is XORed into word1/word2 and 12 rounds run. The tag is {word3 ^ key upper, word4 ^ key lower}. `tag_valid` pulses for one cycle on the 13th cycle after that handshake, and `busy` is low in that same cycle.
- R9: `tag` holds its value until the next `tag_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a message (sampled while idle) |
| no_ad | input | 1 | Message has no associated data (sampled with start) |
| key | input | 128 | Secret key |
| nonce | input | 128 | Nonce |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Block accepted on this edge when valid |
| in_data | input | 64 | Input block, first byte in bits 63:56 |
| in_bytes | input | 3 | Valid bytes in a last block (0..7) |
| in_last | input | 1 | Final block of the current phase |
| busy | output | 1 | A message is in progress |
| ct_valid | output | 1 | Ciphertext block valid (one cycle) |
| ct_data | output | 64 | Ciphertext block, unused bytes zero |
| ct_bytes | output | 4 | Valid bytes in ct_data |
| ct_last | output | 1 | Final ciphertext block |
| tag_valid | output | 1 | Tag valid pulse |
| tag | output | 128 | Authentication tag |

## Verification
The bench builds the block with its defaults: 12 rounds for initialization and finalization, 6 rounds per data block, and the standard IV. As a result, every round constant from index 0 to 11 is exercised, and the expected ciphertext and tag come from a bit-column software model of the exact schedule. Message lengths are chosen so that last blocks take every size class: empty, partial, full with an extra empty pad block, and absent associated data. A start pulse injected in the middle of a message, with a corrupted key, shows that the latched operands survive.

// File: rtl/ascon_enc_pkg.sv
package ascon_enc_pkg;
    localparam int WORD_W     = 64;
    localparam int N_WORDS    = 5;
    localparam int KEY_W      = 2 * WORD_W;
    localparam int BYTES_W    = WORD_W / 8;
    localparam int CNT_W      = $clog2(BYTES_W);
    localparam int MAX_ROUNDS = 12;
    localparam int RND_W      = $clog2(MAX_ROUNDS);

    typedef logic [WORD_W-1:0]        word_t;
    typedef word_t [N_WORDS-1:0]      state_t;   // index 0 is the rate word
    typedef logic [RND_W-1:0]         rnd_t;

    typedef enum logic [1:0] {PH_IDLE, PH_PERM, PH_AD, PH_PT} phase_e;
    typedef enum logic [2:0] {AF_INIT, AF_AD, AF_AD_LAST, AF_PT, AF_FIN} after_e;

    // constant of round r on the 12-round index scale
    function automatic logic [7:0] round_const(rnd_t r);
        return {4'hF - r, r};
    endfunction

    function automatic word_t ror(word_t v, int unsigned n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction

    // bytes kept from the top of a block holding n bytes
    function automatic word_t keep_mask(logic [CNT_W:0] n);
        word_t ones = '1;
        if (n >= (CNT_W+1)'(BYTES_W)) return ones;
        return ~(ones >> (8 * n));
    endfunction

    // single one-bit directly after the n-th byte
    function automatic word_t pad_bit(logic [CNT_W:0] n);
        if (n >= (CNT_W+1)'(BYTES_W)) return '0;
        return word_t'(8'h80) << (8 * (BYTES_W - 1 - int'(n)));
    endfunction

    function automatic int unsigned rot_a(int i);
        case (i)
            0: return 19;
            1: return 61;
            2: return 1;
            3: return 10;
            default: return 7;
        endcase
    endfunction

    function automatic int unsigned rot_b(int i);
        case (i)
            0: return 28;
            1: return 39;
            2: return 6;
            3: return 17;
            default: return 41;
        endcase
    endfunction
endpackage

// File: rtl/ascon_round.sv
module ascon_round
    import ascon_enc_pkg::*;
(
    input  state_t s_in,
    input  rnd_t   rnd,
    output state_t s_out
);
    state_t a;
    state_t b;

    // constant addition and bitsliced 5-bit substitution
    always_comb begin
        word_t t0, t1, t2, t3, t4;
        a = s_in;
        a[2][7:0] = a[2][7:0] ^ round_const(rnd);
        a[0] = a[0] ^ a[4];
        a[4] = a[4] ^ a[3];
        a[2] = a[2] ^ a[1];
        t0 = ~a[0] & a[1];
        t1 = ~a[1] & a[2];
        t2 = ~a[2] & a[3];
        t3 = ~a[3] & a[4];
        t4 = ~a[4] & a[0];
        b[0] = a[0] ^ t1;
        b[1] = a[1] ^ t2;
        b[2] = a[2] ^ t3;
        b[3] = a[3] ^ t4;
        b[4] = a[4] ^ t0;
        b[1] = b[1] ^ b[0];
        b[0] = b[0] ^ b[4];
        b[3] = b[3] ^ b[2];
        b[2] = ~b[2];
    end

    // per-word linear diffusion
    for (genvar g = 0; g < N_WORDS; g++) begin : g_lin
        assign s_out[g] = b[g] ^ ror(b[g], rot_a(g)) ^ ror(b[g], rot_b(g));
    end
endmodule

// File: rtl/ascon_blockpad.sv
module ascon_blockpad
    import ascon_enc_pkg::*;
(
    input  word_t            rate_in,
    input  word_t            data,
    input  logic [CNT_W-1:0] nbytes,
    input  logic             last,
    output word_t            rate_out,
    output word_t            ct,
    output logic [CNT_W:0]   ct_len
);
    word_t keep;

    always_comb begin
        ct_len   = last ? {1'b0, nbytes} : (CNT_W+1)'(BYTES_W);
        keep     = keep_mask(ct_len);
        rate_out = rate_in ^ ((data & keep) | pad_bit(ct_len));
        ct       = rate_out & keep;
    end
endmodule

// File: rtl/ascon128_enc.sv
module ascon128_enc
    import ascon_enc_pkg::*;
#(
    parameter int          ROUNDS_INIT = 12,
    parameter int          ROUNDS_DATA = 6,
    parameter logic [63:0] IV          = 64'h80400c0600000000
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 no_ad,
    input  logic [KEY_W-1:0]     key,
    input  logic [KEY_W-1:0]     nonce,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_data,
    input  logic [CNT_W-1:0]     in_bytes,
    input  logic                 in_last,
    output logic                 busy,
    output logic                 ct_valid,
    output logic [WORD_W-1:0]    ct_data,
    output logic [CNT_W:0]       ct_bytes,
    output logic                 ct_last,
    output logic                 tag_valid,
    output logic [KEY_W-1:0]     tag
);
    localparam rnd_t FIRST_INIT = rnd_t'(MAX_ROUNDS - ROUNDS_INIT);
    localparam rnd_t FIRST_DATA = rnd_t'(MAX_ROUNDS - ROUNDS_DATA);
    localparam rnd_t LAST_RND   = rnd_t'(MAX_ROUNDS - 1);

    phase_e           phase;
    phase_e           goto_ph;
    after_e           after;
    rnd_t             rnd;
    state_t           st;
    state_t           r_out;
    state_t           post;
    logic [KEY_W-1:0] key_q;
    logic             skip_q;
    logic             done_perm;
    word_t            absorbed;
    word_t            ct_word;
    logic [CNT_W:0]   ct_len;
    word_t            k_hi;
    word_t            k_lo;

    assign k_hi = key_q[KEY_W-1 -: WORD_W];
    assign k_lo = key_q[WORD_W-1:0];

    ascon_round u_round (
        .s_in  (st),
        .rnd   (rnd),
        .s_out (r_out)
    );

    ascon_blockpad u_pad (
        .rate_in  (st[0]),
        .data     (in_data),
        .nbytes   (in_bytes),
        .last     (in_last),
        .rate_out (absorbed),
        .ct       (ct_word),
        .ct_len   (ct_len)
    );

    // work done on the last round of each permutation
    always_comb begin
        post      = r_out;
        goto_ph   = PH_PERM;
        done_perm = (rnd == LAST_RND);
        if (done_perm) begin
            case (after)
                AF_INIT: begin
                    post[3] = post[3] ^ k_hi;
                    post[4] = post[4] ^ k_lo;
                    if (skip_q) begin
                        post[4][0] = ~post[4][0];
                        goto_ph    = PH_PT;
                    end else begin
                        goto_ph = PH_AD;
                    end
                end
                AF_AD:      goto_ph = PH_AD;
                AF_AD_LAST: begin
                    post[4][0] = ~post[4][0];
                    goto_ph    = PH_PT;
                end
                AF_PT:      goto_ph = PH_PT;
                default:    goto_ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            after     <= AF_INIT;
            rnd       <= '0;
            st        <= '0;
            key_q     <= '0;
            skip_q    <= 1'b0;
            ct_valid  <= 1'b0;
            ct_data   <= '0;
            ct_bytes  <= '0;
            ct_last   <= 1'b0;
            tag_valid <= 1'b0;
            tag       <= '0;
        end else begin
            ct_valid  <= 1'b0;
            tag_valid <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    st[0]  <= IV;
                    st[1]  <= key[KEY_W-1 -: WORD_W];
                    st[2]  <= key[WORD_W-1:0];
                    st[3]  <= nonce[KEY_W-1 -: WORD_W];
                    st[4]  <= nonce[WORD_W-1:0];
                    key_q  <= key;
                    skip_q <= no_ad;
                    rnd    <= FIRST_INIT;
                    after  <= AF_INIT;
                    phase  <= PH_PERM;
                end
                PH_PERM: begin
                    st  <= post;
                    rnd <= rnd + 1'b1;
                    if (done_perm) begin
                        phase <= goto_ph;
                        if (after == AF_FIN) begin
                            tag_valid <= 1'b1;
                            tag       <= {r_out[3] ^ k_hi, r_out[4] ^ k_lo};
                        end
                    end
                end
                PH_AD: if (in_valid) begin
                    st[0] <= absorbed;
                    rnd   <= FIRST_DATA;
                    after <= in_last ? AF_AD_LAST : AF_AD;
                    phase <= PH_PERM;
                end
                PH_PT: if (in_valid) begin
                    st[0]    <= absorbed;
                    ct_valid <= 1'b1;
                    ct_data  <= ct_word;
                    ct_bytes <= ct_len;
                    ct_last  <= in_last;
                    phase    <= PH_PERM;
                    if (in_last) begin
                        st[1] <= st[1] ^ k_hi;
                        st[2] <= st[2] ^ k_lo;
                        rnd   <= FIRST_INIT;
                        after <= AF_FIN;
                    end else begin
                        rnd   <= FIRST_DATA;
                        after <= AF_PT;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign in_ready = (phase == PH_AD) || (phase == PH_PT);
    assign busy     = (phase != PH_IDLE);
endmodule

// File: rtl/ascon_enc_checks.sv
module ascon_enc_checks (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         busy,
    input logic         ct_valid,
    input logic         ct_last,
    input logic [3:0]   ct_bytes,
    input logic         tag_valid,
    input logic [127:0] tag
);
    a_r3_idle_no_ready: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !in_ready);

    a_r5_perm_after_block: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    a_r7_ct_follows_handshake: assert property (@(posedge clk) disable iff (rst)
        ct_valid |-> $past(in_valid && in_ready));

    a_r7_full_mid_block: assert property (@(posedge clk) disable iff (rst)
        (ct_valid && !ct_last) |-> (ct_bytes == 4'd8));

    a_r8_tag_pulse: assert property (@(posedge clk) disable iff (rst)
        tag_valid |=> !tag_valid);

    a_r8_idle_at_tag: assert property (@(posedge clk) disable iff (rst)
        tag_valid |-> !busy);

    a_r9_tag_hold: assert property (@(posedge clk) disable iff (rst)
        !tag_valid |-> $stable(tag));
endmodule

bind ascon128_enc ascon_enc_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .busy      (busy),
    .ct_valid  (ct_valid),
    .ct_last   (ct_last),
    .ct_bytes  (ct_bytes),
    .tag_valid (tag_valid),
    .tag       (tag)
);

// File: tb/sim_ascon128_enc.sv
`timescale 1ns/1ps
module sim_ascon128_enc;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         no_ad = 1'b0;
    logic [127:0] key = '0;
    logic [127:0] nonce = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [63:0]  in_data = '0;
    logic [2:0]   in_bytes = '0;
    logic         in_last = 1'b0;
    logic         busy;
    logic         ct_valid;
    logic [63:0]  ct_data;
    logic [3:0]   ct_bytes;
    logic         ct_last;
    logic         tag_valid;
    logic [127:0] tag;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    logic [7:0]   adb [0:47];
    logic [7:0]   ptb [0:47];
    logic [63:0]  exp_ct  [0:7];
    logic [3:0]   exp_len [0:7];
    logic [127:0] exp_tag;

    always #2 clk = ~clk;   // 250 MHz

    ascon128_enc #(.ROUNDS_INIT(12), .ROUNDS_DATA(6),
                   .IV(64'h80400c0600000000)) u0 (
        .clk(clk), .rst(rst), .start(start), .no_ad(no_ad), .key(key),
        .nonce(nonce), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_bytes(in_bytes), .in_last(in_last),
        .busy(busy), .ct_valid(ct_valid), .ct_data(ct_data),
        .ct_bytes(ct_bytes), .ct_last(ct_last), .tag_valid(tag_valid),
        .tag(tag)
    );

    task automatic check(input bit ok, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // ---------------- reference model, one bit column at a time -------------
    function automatic logic [63:0] rr(input logic [63:0] v, input int n);
        return (v >> n) | (v << (64 - n));
    endfunction

    function automatic logic [4:0] ref_col(input logic [4:0] v);
        logic a0, a1, a2, a3, a4, t0, t1, t2, t3, t4;
        a0 = v[4] ^ v[0]; a4 = v[0] ^ v[1]; a2 = v[2] ^ v[3];
        a1 = v[3];        a3 = v[1];
        t0 = ~a0 & a1; t1 = ~a1 & a2; t2 = ~a2 & a3; t3 = ~a3 & a4; t4 = ~a4 & a0;
        a0 ^= t1; a1 ^= t2; a2 ^= t3; a3 ^= t4; a4 ^= t0;
        a1 ^= a0; a0 ^= a4; a3 ^= a2; a2 = ~a2;
        return {a0, a1, a2, a3, a4};
    endfunction

    function automatic logic [319:0] ref_perm(input logic [319:0] s, input int first);
        logic [63:0] w [5];
        logic [4:0]  c;
        for (int k = 0; k < 5; k++) w[k] = s[319-64*k -: 64];
        for (int r = first; r < 12; r++) begin
            w[2][7:0] ^= 8'(((15 - r) << 4) | r);
            for (int b = 0; b < 64; b++) begin
                c = ref_col({w[0][b], w[1][b], w[2][b], w[3][b], w[4][b]});
                w[0][b] = c[4]; w[1][b] = c[3]; w[2][b] = c[2];
                w[3][b] = c[1]; w[4][b] = c[0];
            end
            w[0] = w[0] ^ rr(w[0], 19) ^ rr(w[0], 28);
            w[1] = w[1] ^ rr(w[1], 61) ^ rr(w[1], 39);
            w[2] = w[2] ^ rr(w[2], 1)  ^ rr(w[2], 6);
            w[3] = w[3] ^ rr(w[3], 10) ^ rr(w[3], 17);
            w[4] = w[4] ^ rr(w[4], 7)  ^ rr(w[4], 41);
        end
        return {w[0], w[1], w[2], w[3], w[4]};
    endfunction

    function automatic logic [63:0] get_block(input bit pt, input int j, input int cnt);
        logic [63:0] v = '0;
        for (int i = 0; i < cnt; i++)
            v[63-8*i -: 8] = pt ? ptb[8*j+i] : adb[8*j+i];
        return v;
    endfunction

    task automatic model(input int adl, input int ptl, input bit skip,
                         input logic [127:0] k, input logic [127:0] n);
        logic [319:0] s;
        logic [63:0]  b;
        int nb, cnt;
        s = {64'h80400c0600000000, k, n};
        s = ref_perm(s, 0);
        s[127:0] ^= k;
        if (!skip) begin
            nb = adl / 8 + 1;
            for (int j = 0; j < nb; j++) begin
                cnt = (j == nb - 1) ? adl % 8 : 8;
                b = get_block(0, j, cnt);
                if (cnt < 8) b[63-8*cnt -: 8] = 8'h80;
                s[319:256] ^= b;
                s = ref_perm(s, 6);
            end
        end
        s[0] = ~s[0];
        nb = ptl / 8 + 1;
        for (int j = 0; j < nb; j++) begin
            cnt = (j == nb - 1) ? ptl % 8 : 8;
            b = get_block(1, j, cnt);
            if (cnt < 8) b[63-8*cnt -: 8] = 8'h80;
            s[319:256] ^= b;
            b = s[319:256];
            for (int i = cnt; i < 8; i++) b[63-8*i -: 8] = 8'h00;
            exp_ct[j]  = b;
            exp_len[j] = 4'(cnt);
            if (j != nb - 1) s = ref_perm(s, 6);
        end
        s[255:128] ^= k;
        s = ref_perm(s, 0);
        exp_tag = s[127:0] ^ k;
    endtask

    // ---------------- drivers ----------------
    task automatic send_block(input string nm, input bit pt, input int j,
                              input int cnt, input bit last, input bit poke,
                              output int k);
        logic [63:0] junk = 64'hA5A5_A5A5_A5A5_A5A5;
        logic [63:0] d = get_block(pt, j, cnt);
        for (int i = cnt; i < 8; i++) d[63-8*i -: 8] = junk[7:0];
        in_data  = d;
        in_bytes = last ? 3'(cnt) : 3'd3;
        in_last  = last;
        in_valid = 1'b1;
        @(posedge clk);
        k = 0;
        forever begin
            @(negedge clk);
            if (k == 0) in_valid = 1'b0;
            k++;
            if (k == 1) begin
                if (pt) begin
                    check(ct_valid === 1'b1, {nm, " R7 ct_valid"}, 128'(ct_valid), 128'd1);
                    check(ct_data === exp_ct[j], {nm, " R4 R7 ct_data"}, 128'(ct_data), 128'(exp_ct[j]));
                    check(ct_bytes === exp_len[j], {nm, " R7 ct_bytes"}, 128'(ct_bytes), 128'(exp_len[j]));
                    check(ct_last === last, {nm, " R7 ct_last"}, 128'(ct_last), 128'(last));
                end else begin
                    check(ct_valid === 1'b0, {nm, " R7 no ct for AD"}, 128'(ct_valid), 128'd0);
                end
            end
            if (k == 2 && !pt) check(ct_valid === 1'b0, {nm, " R7 ct one cycle"}, 128'(ct_valid), 128'd0);
            if (poke && k == 2) begin start = 1'b1; key = ~key; nonce = ~nonce; end
            if (poke && k == 3) start = 1'b0;
            if (pt && last) begin
                if (tag_valid === 1'b1 || k > 60) break;
            end else begin
                if (in_ready === 1'b1 || k > 60) break;
            end
        end
    endtask

    task automatic run_msg(input string nm, input int adl, input int ptl,
                           input bit skip, input bit poke);
        logic [127:0] kv, nv;
        int k, nb, cnt;
        kv = {$urandom, $urandom, $urandom, $urandom};
        nv = {$urandom, $urandom, $urandom, $urandom};
        for (int i = 0; i < 48; i++) begin
            adb[i] = 8'($urandom);
            ptb[i] = 8'($urandom);
        end
        model(adl, ptl, skip, kv, nv);

        @(negedge clk);
        key = kv; nonce = nv; no_ad = skip; start = 1'b1;
        @(posedge clk);
        k = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            k++;
            if (k == 1) check(busy === 1'b1, {nm, " R2 busy after start"}, 128'(busy), 128'd1);
            if (in_ready === 1'b1 || k > 60) break;
        end
        check(k == 13, {nm, " R2 init latency"}, 128'(k), 128'd13);

        if (!skip) begin
            nb = adl / 8 + 1;
            for (int j = 0; j < nb; j++) begin
                cnt = (j == nb - 1) ? adl % 8 : 8;
                send_block(nm, 0, j, cnt, j == nb - 1, poke && j == 0, k);
                check(k == 7, {nm, " R5 AD block rounds"}, 128'(k), 128'd7);
            end
        end
        nb = ptl / 8 + 1;
        for (int j = 0; j < nb; j++) begin
            cnt = (j == nb - 1) ? ptl % 8 : 8;
            send_block(nm, 1, j, cnt, j == nb - 1, poke && skip && j == 0, k);
            if (j != nb - 1)
                check(k == 7, {nm, " R5 PT block rounds"}, 128'(k), 128'd7);
        end
        check(k == 13, {nm, " R8 tag latency"}, 128'(k), 128'd13);
        check(tag === exp_tag, {nm, " R2 R3 R6 R8 tag"}, tag, exp_tag);
        check(busy === 1'b0, {nm, " R8 idle at tag"}, 128'(busy), 128'd0);
        @(negedge clk);
        check(tag_valid === 1'b0, {nm, " R8 tag pulse"}, 128'(tag_valid), 128'd0);
        check(tag === exp_tag, {nm, " R9 tag held"}, tag, exp_tag);
        check(in_ready === 1'b0, {nm, " R3 no ready idle"}, 128'(in_ready), 128'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (4) @(negedge clk);
        check(busy === 1'b0 && in_ready === 1'b0, "R1 busy/ready in reset",
              128'({busy, in_ready}), 128'd0);
        check(ct_valid === 1'b0 && tag_valid === 1'b0, "R1 valids in reset",
              128'({ct_valid, tag_valid}), 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && in_ready === 1'b0 && tag_valid === 1'b0,
              "R1 idle after reset", 128'({busy, in_ready, tag_valid}), 128'd0);
    endtask

    task automatic t_empty_message();   run_msg("empty",   0,  0, 1, 0); endtask
    task automatic t_short_partial();   run_msg("short",   5,  3, 0, 0); endtask
    task automatic t_aligned_lengths(); run_msg("aligned", 16, 24, 0, 0); endtask
    task automatic t_long_plaintext();  run_msg("long",    3, 37, 0, 0); endtask
    task automatic t_no_assoc();        run_msg("noad",    0, 20, 1, 0); endtask  // R6
    task automatic t_ad_only();         run_msg("adonly",  9,  0, 0, 0); endtask
    task automatic t_start_ignored();   run_msg("poke",   10, 10, 0, 1); endtask  // R3
    task automatic t_start_ignored_pt(); run_msg("poke_pt", 0, 17, 1, 1); endtask // R3

    initial begin
        t_reset();
        t_empty_message();
        t_short_partial();
        t_aligned_lengths();
        t_long_plaintext();
        t_no_assoc();
        t_ad_only();
        t_start_ignored();
        t_start_ignored_pt();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R2 R8 watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule